// File: doc/BRIEF.md
# DMA Channel Register Front End

This block holds the software-visible registers of a multi-channel, descriptor-driven DMA engine. A host issues 32-bit register reads and writes on a simple single-cycle bus. The byte address selects a channel through its upper bits and a word register inside that channel's window through the bits below them. The bus has no back-pressure: every access is taken in the cycle it is presented. Read data appears on `bus_rdata` in the cycle after the read strobe.

Software starts, pauses, wakes and flushes a channel by writing its control word. The upper half of that word is a bit-enable mask and the lower half carries the new bit values. The block merges this into the channel's status word and works out the derived active and dead flags. It then signals the command sequencer with a one-cycle kick when the channel is left active, and a one-cycle flush request when the channel's buffers must be drained. The command pointer is locked while the channel is active. An accepted pointer is aligned to 16 bytes and produces a one-cycle fetch request. The status word and command pointer of each channel are driven out continuously for the sequencer.

The status word uses this bit layout:

| Field | Bit(s) |
|---|---|
| RUN | 15 |
| PAUSE | 14 |
| FLUSH | 13 |
| WAKE | 12 |
| DEAD | 11 |
| ACTIVE | 10 |
| BT | 8 |
| Device status | 7:0 |

The register index is the word address within a channel window. The register map is:

| Index | Register | Behaviour |
|---|---|---|
| 0 | Control | Write only; reads 0 |
| 1 | Status | Read/write |
| 2 | Command pointer | Read/write, locked while ACTIVE |
| 3, 4, 5 | Interrupt, branch and wait select words | Read/write |
| 6 to 11 | Unused | Reads 0, writes dropped |
| 12 to 15 | Scratch | Read/write |

Top module: `dma_chan_regs`

## Requirements
- R1: A control write (index 0) with word W updates status bit b, for b in {15:12, 7:0}, to W[b] when the mask bit W[16+b] is 1. The bit keeps its old value when the mask bit is 0.
- R2: A control write never changes status bits 11:8 or 31:16 through its mask and value fields. BT (bit 8) keeps any value written earlier through the status register.
- R3: After the masked merge, WAKE set forces ACTIVE (bit 10) to 1, and RUN set forces ACTIVE to 1 and clears DEAD (bit 11). PAUSE set then clears ACTIVE, so PAUSE wins over RUN and WAKE.
- R4: A control write that takes RUN from 1 to 0 clears ACTIVE and DEAD. If FLUSH is set at that moment, it also clears FLUSH and pulses `flush_req` for one cycle. A control write that leaves FLUSH set also pulses `flush_req`.
- R5: A command-pointer write (index 2) is discarded while ACTIVE is 1. An accepted write stores the value with bits 3:0 forced to 0 and pulses `fetch_req` for one cycle.
- R6: `kick` pulses for exactly one cycle after a control write that leaves ACTIVE set. No other access raises it.
- R7: Reads return the control register and unused indices 6 to 11 as 0. The status, command pointer, select words (3 to 5) and scratch words (12 to 15) read back as stored. Read data appears in the cycle after the read strobe.
- R8: An access whose byte enables are not 4'hF, or whose address bits 1:0 are not 0, is ignored. A write changes nothing, and a read returns 0.
- R9: Address bits above bit 5 select the channel. An access to one channel leaves every other channel's registers and pulses untouched.
- R10: Reset clears every register of every channel, and all pulse outputs, to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 4 | Byte enables; only 4'hF is valid |
| bus_addr | input | ADDR_W | Byte address: channel, register index, 2'b00 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the strobe |
| chan_status | output | NUM_CH*32 | Status word of each channel, channel 0 lowest |
| chan_cmd_ptr | output | NUM_CH*32 | Command pointer of each channel |
| kick | output | NUM_CH | One-cycle start request to the sequencer |
| flush_req | output | NUM_CH | One-cycle flush request |
| fetch_req | output | NUM_CH | One-cycle descriptor fetch request |

## Verification
A wrong merge or a wrong derivation of the active and dead flags appears on `chan_status` in the cycle right after the control write. It also shows as a missing or extra `kick` or `flush_req` in that same cycle. Because of this, each scenario compares the status word and the pulses one cycle after each write. A lock on the command pointer that fails to hold is visible the next cycle as a changed `chan_cmd_ptr` with a stray `fetch_req`. A decode error that reaches the wrong channel shows when the other channels' status words are read back.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;
  localparam int IDX_W  = 4;

  localparam int B_RUN    = 15;
  localparam int B_PAUSE  = 14;
  localparam int B_FLUSH  = 13;
  localparam int B_WAKE   = 12;
  localparam int B_DEAD   = 11;
  localparam int B_ACTIVE = 10;
  localparam int B_BT     = 8;

  localparam logic [HALF_W-1:0] CTRL_WRITABLE = 16'hF0FF;

  localparam logic [IDX_W-1:0] RI_CTRL = 4'd0;
  localparam logic [IDX_W-1:0] RI_STAT = 4'd1;
  localparam logic [IDX_W-1:0] RI_CPTR = 4'd2;
  localparam logic [IDX_W-1:0] RI_ISEL = 4'd3;
  localparam logic [IDX_W-1:0] RI_BSEL = 4'd4;
  localparam logic [IDX_W-1:0] RI_WSEL = 4'd5;
  localparam int SPARE_BASE = 12;
  localparam int NUM_SPARE  = 4;

  typedef struct packed {
    logic             wr_ok;
    logic             rd_ok;
    logic [IDX_W-1:0] idx;
  } acc_t;
endpackage

// File: rtl/dma_access_decode.sv
module dma_access_decode
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  parameter int ADDR_W = 8
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_be,
  input  logic [ADDR_W-1:0] bus_addr,
  output acc_t              acc,
  output logic [CH_W-1:0]   ch_sel,
  output logic [NUM_CH-1:0] ch_wr
);
  localparam int CH_LSB = IDX_W + 2;

  logic legal;

  always_comb begin
    ch_sel    = bus_addr[ADDR_W-1:CH_LSB];
    legal     = (bus_be == 4'hF) && (bus_addr[1:0] == 2'b00) &&
                (int'(ch_sel) < NUM_CH);
    acc.wr_ok = bus_wr && legal;
    acc.rd_ok = bus_rd && legal;
    acc.idx   = bus_addr[CH_LSB-1:2];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    assign ch_wr[c] = acc.wr_ok && (int'(ch_sel) == c);
  end
endmodule

// File: rtl/dma_ctrl_update.sv
module dma_ctrl_update
  import dma_regs_pkg::*;
(
  input  logic [WORD_W-1:0] old_stat,
  input  logic [WORD_W-1:0] ctrl_word,
  output logic [WORD_W-1:0] new_stat,
  output logic              flush_on_stop
);
  logic [HALF_W-1:0] en;
  logic [HALF_W-1:0] val;
  logic [WORD_W-1:0] s;

  always_comb begin
    en  = ctrl_word[WORD_W-1:HALF_W] & CTRL_WRITABLE;
    val = ctrl_word[HALF_W-1:0];
    s   = old_stat;
    s[HALF_W-1:0] = (val & en) | (old_stat[HALF_W-1:0] & ~en);
    if (s[B_WAKE]) s[B_ACTIVE] = 1'b1;
    if (s[B_RUN]) begin
      s[B_ACTIVE] = 1'b1;
      s[B_DEAD]   = 1'b0;
    end
    if (s[B_PAUSE]) s[B_ACTIVE] = 1'b0;
    flush_on_stop = 1'b0;
    if (old_stat[B_RUN] && !s[B_RUN]) begin
      s[B_ACTIVE] = 1'b0;
      s[B_DEAD]   = 1'b0;
      if (s[B_FLUSH]) begin
        flush_on_stop = 1'b1;
        s[B_FLUSH]    = 1'b0;
      end
    end
    new_stat = s;
  end
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
  import dma_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] status_q,
  output logic [WORD_W-1:0] cmd_ptr_q,
  output logic [WORD_W-1:0] rd_word,
  output logic              kick_q,
  output logic              flush_q,
  output logic              fetch_q
);
  logic [WORD_W-1:0] isel_q, bsel_q, wsel_q;
  logic [WORD_W-1:0] spare_q [NUM_SPARE];
  logic [WORD_W-1:0] upd_stat;
  logic              flush_on_stop;
  logic              ctrl_we, stat_we, cptr_we;

  assign ctrl_we = wr_en && (idx == RI_CTRL);
  assign stat_we = wr_en && (idx == RI_STAT);
  assign cptr_we = wr_en && (idx == RI_CPTR);

  dma_ctrl_update u_upd (
    .old_stat      (status_q),
    .ctrl_word     (wdata),
    .new_stat      (upd_stat),
    .flush_on_stop (flush_on_stop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      cmd_ptr_q <= '0;
      isel_q    <= '0;
      bsel_q    <= '0;
      wsel_q    <= '0;
      kick_q    <= 1'b0;
      flush_q   <= 1'b0;
      fetch_q   <= 1'b0;
    end else begin
      kick_q  <= 1'b0;
      flush_q <= 1'b0;
      fetch_q <= 1'b0;
      if (ctrl_we) begin
        status_q <= upd_stat;
        kick_q   <= upd_stat[B_ACTIVE];
        flush_q  <= flush_on_stop | upd_stat[B_FLUSH];
      end else if (stat_we) begin
        status_q <= wdata;
      end
      if (cptr_we && !status_q[B_ACTIVE]) begin
        cmd_ptr_q <= {wdata[WORD_W-1:4], 4'b0000};
        fetch_q   <= 1'b1;
      end
      if (wr_en && idx == RI_ISEL) isel_q <= wdata;
      if (wr_en && idx == RI_BSEL) bsel_q <= wdata;
      if (wr_en && idx == RI_WSEL) wsel_q <= wdata;
    end
  end

  for (genvar k = 0; k < NUM_SPARE; k++) begin : g_spare
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) spare_q[k] <= '0;
      else if (wr_en && int'(idx) == SPARE_BASE + k) spare_q[k] <= wdata;
    end
  end

  always_comb begin
    rd_word = '0;
    if (idx == RI_STAT)      rd_word = status_q;
    else if (idx == RI_CPTR) rd_word = cmd_ptr_q;
    else if (idx == RI_ISEL) rd_word = isel_q;
    else if (idx == RI_BSEL) rd_word = bsel_q;
    else if (idx == RI_WSEL) rd_word = wsel_q;
    else if (int'(idx) >= SPARE_BASE)
      rd_word = spare_q[int'(idx) - SPARE_BASE];
  end

  // R3: pause written as 1 leaves the channel inactive
  a_r3_pause_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && wdata[HALF_W+B_PAUSE] && wdata[B_PAUSE]) |=> !status_q[B_ACTIVE]);

  // R4: stopping clears active and dead
  a_r4_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && status_q[B_RUN] && wdata[HALF_W+B_RUN] && !wdata[B_RUN])
    |=> (!status_q[B_ACTIVE] && !status_q[B_DEAD]));

  // R5: pointer is held while active
  a_r5_ptr_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cptr_we && status_q[B_ACTIVE]) |=> ($stable(cmd_ptr_q) && !fetch_q));

  // R6: a kick always sees an active channel and follows a control write
  a_r6_kick_active: assert property (@(posedge clk) disable iff (!rst_n)
    kick_q |-> (status_q[B_ACTIVE] && $past(ctrl_we)));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + IDX_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [3:0]               bus_be,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [WORD_W-1:0]        bus_wdata,
  output logic [WORD_W-1:0]        bus_rdata,
  output logic [NUM_CH*WORD_W-1:0] chan_status,
  output logic [NUM_CH*WORD_W-1:0] chan_cmd_ptr,
  output logic [NUM_CH-1:0]        kick,
  output logic [NUM_CH-1:0]        flush_req,
  output logic [NUM_CH-1:0]        fetch_req
);
  acc_t              acc;
  logic [CH_W-1:0]   ch_sel;
  logic [NUM_CH-1:0] ch_wr;
  logic [WORD_W-1:0] rd_words [NUM_CH];
  logic [WORD_W-1:0] rd_pick;

  dma_access_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_be   (bus_be),
    .bus_addr (bus_addr),
    .acc      (acc),
    .ch_sel   (ch_sel),
    .ch_wr    (ch_wr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_chan_regfile u_rf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (ch_wr[c]),
      .idx       (acc.idx),
      .wdata     (bus_wdata),
      .status_q  (chan_status[c*WORD_W +: WORD_W]),
      .cmd_ptr_q (chan_cmd_ptr[c*WORD_W +: WORD_W]),
      .rd_word   (rd_words[c]),
      .kick_q    (kick[c]),
      .flush_q   (flush_req[c]),
      .fetch_q   (fetch_req[c])
    );
  end

  always_comb begin
    rd_pick = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (int'(ch_sel) == c) rd_pick = rd_words[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= (acc.rd_ok && acc.idx != RI_CTRL) ? rd_pick : '0;
  end

  // R8: an illegal access never reaches any channel
  a_r8_illegal_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_be != 4'hF || bus_addr[1:0] != 2'b00) |-> (ch_wr == '0));

  // R9: at most one channel is written per access
  a_r9_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_wr));

  // R7: a read of the control word returns zero
  a_r7_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[IDX_W+1:0] == '0) |=> (bus_rdata == '0));
endmodule

// File: tb/dma_chan_regs_bench.sv
module dma_chan_regs_bench;
  localparam int NCH = 4;
  localparam int AW  = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]      bus_be = 4'hF;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCH*32-1:0] chan_status, chan_cmd_ptr;
  logic [NCH-1:0]  kick, flush_req, fetch_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [NCH-1:0] k_seen, f_seen, p_seen;
  logic [31:0]    rd_val;

  always #5 clk = ~clk;

  dma_chan_regs #(.NUM_CH(NCH)) u_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_be(bus_be), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .chan_status(chan_status),
    .chan_cmd_ptr(chan_cmd_ptr), .kick(kick), .flush_req(flush_req),
    .fetch_req(fetch_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] adr(input int ch, input int idx);
    return AW'((ch << 6) | (idx << 2));
  endfunction

  task automatic wr(input int ch, input int idx, input logic [31:0] d,
                    input logic [3:0] be = 4'hF, input logic [1:0] lo = 2'b00);
    @(negedge clk);
    bus_wr = 1'b1; bus_be = be; bus_addr = adr(ch, idx) | AW'(lo); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'hF;
    k_seen = kick; f_seen = flush_req; p_seen = fetch_req;
  endtask

  task automatic rd(input int ch, input int idx, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_rd = 1'b1; bus_be = be; bus_addr = adr(ch, idx);
    @(negedge clk);
    bus_rd = 1'b0; bus_be = 4'hF;
    rd_val = bus_rdata;
  endtask

  function automatic logic [31:0] st(input int ch);
    return chan_status[ch*32 +: 32];
  endfunction

  task automatic t_reset();
    for (int c = 0; c < NCH; c++) check("R10 status", st(c), 32'h0);
    check("R10 pulses", {29'b0, |kick, |flush_req, |fetch_req}, 32'h0);
    rd(2, 1);
    check("R10 readback", rd_val, 32'h0);
  endtask

  task automatic t_masked_merge();
    wr(0, 0, 32'h00FF_005A);
    check("R1 merge", st(0), 32'h0000_005A);
    check("R6 no kick inactive", {31'b0, k_seen[0]}, 32'h0);
    wr(0, 0, 32'h000F_0003);
    check("R1 partial mask", st(0), 32'h0000_0053);
    rd(0, 0);
    check("R7 ctrl reads zero", rd_val, 32'h0);
  endtask

  task automatic t_protected_bits();
    wr(0, 1, 32'h0000_0100);
    check("R2 status write", st(0), 32'h0000_0100);
    wr(0, 0, 32'h0F00_0000);
    check("R2 BT untouched", st(0), 32'h0000_0100);
    wr(0, 0, 32'h0C00_0C00);
    check("R2 active/dead not writable", st(0), 32'h0000_0100);
  endtask

  task automatic t_run_pause_wake();
    wr(1, 1, 32'h0000_0800);
    wr(1, 0, 32'h8000_8000);
    check("R3 run sets active clears dead", st(1), 32'h0000_8400);
    check("R6 kick on run", {31'b0, k_seen[1]}, 32'h1);
    @(negedge clk);
    check("R6 kick one cycle", {31'b0, kick[1]}, 32'h0);
    wr(1, 0, 32'h4000_4000);
    check("R3 pause wins over run", st(1), 32'h0000_C000);
    check("R6 no kick when paused", {31'b0, k_seen[1]}, 32'h0);
    wr(1, 0, 32'h4000_0000);
    check("R3 unpause resumes", st(1), 32'h0000_8400);
    check("R6 kick on resume", {31'b0, k_seen[1]}, 32'h1);
    wr(2, 0, 32'h1000_1000);
    check("R3 wake sets active", st(2), 32'h0000_1400);
    wr(3, 0, 32'h5000_5000);
    check("R3 pause wins over wake", st(3), 32'h0000_5000);
    check("R6 no kick wake+pause", {31'b0, k_seen[3]}, 32'h0);
  endtask

  task automatic t_flush();
    wr(1, 0, 32'h2000_2000);
    check("R4 flush while running", st(1), 32'h0000_A400);
    check("R4 flush pulse", {31'b0, f_seen[1]}, 32'h1);
    wr(1, 0, 32'h8000_0000);
    check("R4 stop clears active/flush", st(1), 32'h0);
    check("R4 flush on stop", {31'b0, f_seen[1]}, 32'h1);
    check("R6 no kick on stop", {31'b0, k_seen[1]}, 32'h0);
  endtask

  task automatic t_cmd_ptr();
    wr(1, 2, 32'h1234_567F);
    check("R5 aligned pointer", chan_cmd_ptr[1*32 +: 32], 32'h1234_5670);
    check("R5 fetch pulse", {31'b0, p_seen[1]}, 32'h1);
    rd(1, 2);
    check("R5 pointer readback", rd_val, 32'h1234_5670);
    wr(2, 2, 32'hAAAA_0000);
    check("R5 locked while active", chan_cmd_ptr[2*32 +: 32], 32'h0);
    check("R5 no fetch while active", {31'b0, p_seen[2]}, 32'h0);
  endtask

  task automatic t_readback();
    wr(0, 7, 32'hDEAD_BEEF);
    rd(0, 7);
    check("R7 unused reads zero", rd_val, 32'h0);
    wr(0, 12, 32'h0BAD_F00D);
    rd(0, 12);
    check("R7 scratch readback", rd_val, 32'h0BAD_F00D);
    wr(3, 3, 32'h000F_0005);
    rd(3, 3);
    check("R7 select readback", rd_val, 32'h000F_0005);
  endtask

  task automatic t_illegal();
    wr(3, 1, 32'h0000_0000, 4'h3);
    check("R8 partial write dropped", st(3), 32'h0000_5000);
    wr(3, 1, 32'h0000_0000, 4'hF, 2'b01);
    check("R8 misaligned write dropped", st(3), 32'h0000_5000);
    rd(3, 1, 4'h3);
    check("R8 partial read zero", rd_val, 32'h0);
  endtask

  task automatic t_isolation();
    check("R9 ch0 untouched", st(0), 32'h0000_0100);
    check("R9 ch2 untouched", st(2), 32'h0000_1400);
    check("R9 ch0 ptr untouched", chan_cmd_ptr[0 +: 32], 32'h0);
    rd(2, 1);
    check("R9 channel select read", rd_val, 32'h0000_1400);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_masked_merge();
    t_protected_bits();
    t_run_pause_wake();
    t_flush();
    t_cmd_ptr();
    t_readback();
    t_illegal();
    t_isolation();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule